// File: doc/BRIEF.md
# Multiplexed ADC Channel Sequencer

This block steps a single shared analog-to-digital converter through a fixed list of monitored quantities. The quantities are die temperature, supply voltage, transmit bias, a coarse and a fine receive-power reading, and transmit power. For each conversion step it presents a channel code, pulses a conversion start and then waits for the converter's done strobe before it moves on.

Transmit bias and transmit power reach the converter through one shared monitor pin on an external laser driver. The sequencer therefore places a select-toggle step after each of these readings. In a toggle step it raises a request to a serial transfer engine, which is outside this block, and holds the request until that engine acknowledges.

A restricted start-up loop is also built in. If the supply-low check is enabled while reset is held, the sequencer cycles only between temperature and supply. It leaves that loop the first time a supply conversion completes with the supply-above-threshold flag set. From then on it runs the full eight-step round.

Top module: `adc_round_robin_seq`

## Requirements
- R1: While reset is held, and after reset until a one-cycle `start_i` pulse is seen, `conv_start_o`, `toggle_req_o` and `cycle_end_o` are 0 and `chan_id_o` is 0. A reset taken in the middle of a sequence returns the block to this idle state.
- R2: In each conversion step, `conv_start_o` is high for exactly one clock. `conv_done_i` is ignored during that clock. The step advances on the first clock edge after it where `conv_done_i` is high, and the next step's outputs appear in the following cycle.
- R3: The full round is temperature (code 0), supply (1), transmit bias (2), toggle, receive coarse (3), receive fine (4), transmit power (5), toggle, and then back to temperature. `chan_id_o` carries the 3-bit code of the current conversion step.
- R4: A toggle step holds `toggle_req_o` high and `conv_start_o` low until `toggle_ack_i` is sampled high. It then advances on that edge. During a toggle step, `chan_id_o` shows the code of the conversion that follows it: 3 after the first toggle and 0 after the second.
- R5: `cycle_end_o` is a one-clock pulse. It is high exactly in the cycle in which the sequence has returned to temperature, which is the same cycle as that step's `conv_start_o`. It is not raised for the very first temperature step after `start_i`.
- R6: The value of `vlow_chk_en_i` sampled while reset is held selects the restricted loop. Changes to it after reset have no effect.
- R7: In the restricted loop, a supply conversion that completes with `vlow_ok_i` high is followed by transmit bias, and the full round is kept from then on whatever `vlow_ok_i` does.
- R8: In the restricted loop, a supply conversion that completes with `vlow_ok_i` low is followed by temperature, and `cycle_end_o` pulses there.
- R9: Without the restricted loop, `vlow_ok_i` has no effect on the order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Pulse that launches sequencing |
| conv_done_i | input | 1 | Converter finished the requested conversion |
| vlow_ok_i | input | 1 | Supply reading is above the low threshold |
| vlow_chk_en_i | input | 1 | Supply-low check enabled; sampled during reset |
| toggle_ack_i | input | 1 | Serial engine accepted the select-toggle command |
| chan_id_o | output | 3 | Channel code of the current or next conversion |
| conv_start_o | output | 1 | One-cycle conversion request |
| toggle_req_o | output | 1 | Monitor select-toggle request, held until acknowledged |
| cycle_end_o | output | 1 | One-cycle pulse on return to temperature |

## Verification
The assertions assume that the converter raises `conv_done_i` only for a conversion this block has requested. They also assume the serial engine acknowledges only a pending toggle, and that `vlow_chk_en_i` is held steady around reset. The stimulus answers each request with a single-cycle done or acknowledge pulse after a latency that is swept from zero to three cycles. In some steps it adds a stray done during the start clock to show that the strobe is ignored there. The supply flag changes only in the scenarios that test it, and the enable is changed only while reset is applied or, for R6, afterwards on purpose.

// File: rtl/adc_seq_pkg.sv
// Package: step encoding, channel codes and the fixed step order of the
// channel sequencer. Assumes the round has exactly eight steps.
package adc_seq_pkg;

    localparam int CHAN_W = 3;

    typedef enum logic [2:0] {
        ST_TEMP  = 3'd0,
        ST_VCC   = 3'd1,
        ST_TXB   = 3'd2,
        ST_TOG_A = 3'd3,
        ST_RXC   = 3'd4,
        ST_RXF   = 3'd5,
        ST_TXP   = 3'd6,
        ST_TOG_B = 3'd7
    } step_e;

    localparam logic [CHAN_W-1:0] CH_TEMP = 3'd0;
    localparam logic [CHAN_W-1:0] CH_VCC  = 3'd1;
    localparam logic [CHAN_W-1:0] CH_TXB  = 3'd2;
    localparam logic [CHAN_W-1:0] CH_RXC  = 3'd3;
    localparam logic [CHAN_W-1:0] CH_RXF  = 3'd4;
    localparam logic [CHAN_W-1:0] CH_TXP  = 3'd5;

    // True for the two monitor select-toggle steps
    function automatic logic is_toggle(step_e s);
        return (s == ST_TOG_A) || (s == ST_TOG_B);
    endfunction

    // Channel code shown for a step; toggle steps show the following conversion
    function automatic logic [CHAN_W-1:0] chan_of(step_e s);
        logic [CHAN_W-1:0] c;
        case (s)
            ST_TEMP:  c = CH_TEMP;
            ST_VCC:   c = CH_VCC;
            ST_TXB:   c = CH_TXB;
            ST_TOG_A: c = CH_RXC;
            ST_RXC:   c = CH_RXC;
            ST_RXF:   c = CH_RXF;
            ST_TXP:   c = CH_TXP;
            default:  c = CH_TEMP;
        endcase
        return c;
    endfunction

    // Successor of a step in the full round
    function automatic step_e follow(step_e s);
        step_e n;
        case (s)
            ST_TEMP:  n = ST_VCC;
            ST_VCC:   n = ST_TXB;
            ST_TXB:   n = ST_TOG_A;
            ST_TOG_A: n = ST_RXC;
            ST_RXC:   n = ST_RXF;
            ST_RXF:   n = ST_TXP;
            ST_TXP:   n = ST_TOG_B;
            default:  n = ST_TEMP;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/seq_step_engine.sv
// Step engine: holds the current step, the run flag and the restricted
// start-up flag. Advances one step per adv_i and resolves the branch
// taken after a supply conversion.
// Assumes adv_i is only raised while run_o is high.
module seq_step_engine
    import adc_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    input  logic  adv_i,
    input  logic  vlow_ok_i,
    input  logic  chk_en_i,
    output logic  run_o,
    output step_e step_o,
    output logic  wrap_o
);

    step_e step_q, step_d;
    logic  run_q, restrict_q, restrict_d, wrap_q, wrap_d;

    // Next step, restricted-flag and wrap computation
    always_comb begin
        step_d     = step_q;
        restrict_d = restrict_q;
        wrap_d     = 1'b0;
        if (adv_i) begin
            if (step_q == ST_VCC && restrict_q) begin
                if (vlow_ok_i) begin
                    step_d     = ST_TXB;
                    restrict_d = 1'b0;
                end else begin
                    step_d = ST_TEMP;
                    wrap_d = 1'b1;
                end
            end else begin
                step_d = follow(step_q);
                wrap_d = (step_q == ST_TOG_B);
            end
        end
    end

    // State registers; restricted mode loads from the enable during reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q     <= ST_TEMP;
            run_q      <= 1'b0;
            restrict_q <= chk_en_i;
            wrap_q     <= 1'b0;
        end else begin
            step_q     <= step_d;
            restrict_q <= restrict_d;
            wrap_q     <= wrap_d;
            if (start_i) run_q <= 1'b1;
        end
    end

    assign run_o  = run_q;
    assign step_o = step_q;
    assign wrap_o = wrap_q;

    // R2
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(step_q));
    // R8
    restrict_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restrict_q && adv_i && step_q == ST_VCC && !vlow_ok_i) |=> (step_q == ST_TEMP && wrap_q));
    // R7
    restrict_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restrict_q |=> !restrict_q);

endmodule

// File: rtl/seq_handshake.sv
// Handshake unit: for a conversion step issues a one-cycle start and waits
// for done; for a toggle step holds the request until acknowledged.
// Produces the advance strobe for the step engine.
// Assumes done/ack only arrive in answer to this block's own requests.
module seq_handshake
    import adc_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run_i,
    input  step_e step_i,
    input  logic  conv_done_i,
    input  logic  toggle_ack_i,
    output logic  conv_start_o,
    output logic  toggle_req_o,
    output logic  adv_o
);

    logic waiting_q;
    logic tog;

    assign tog = is_toggle(step_i);

    // Tracks whether the current conversion has been issued
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting_q <= 1'b0;
        end else if (run_i && !tog) begin
            if (!waiting_q)      waiting_q <= 1'b1;
            else if (conv_done_i) waiting_q <= 1'b0;
        end
    end

    // Request outputs and advance strobe
    always_comb begin
        conv_start_o = run_i && !tog && !waiting_q;
        toggle_req_o = run_i && tog;
        adv_o        = run_i && (tog ? toggle_ack_i : (waiting_q && conv_done_i));
    end

    // R2
    conv_start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);
    // R4
    toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle_req_o && !toggle_ack_i) |=> toggle_req_o);
    // R4
    no_conv_in_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(toggle_req_o && conv_start_o));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> (!conv_start_o && !toggle_req_o));

endmodule

// File: rtl/adc_round_robin_seq.sv
// Top of the multiplexed channel sequencer: step engine plus handshake
// unit, with the channel code decoded from the current step.
// Assumes a synchronous active-low reset and a single clock domain.
module adc_round_robin_seq
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              conv_done_i,
    input  logic              vlow_ok_i,
    input  logic              vlow_chk_en_i,
    input  logic              toggle_ack_i,
    output logic [CHAN_W-1:0] chan_id_o,
    output logic              conv_start_o,
    output logic              toggle_req_o,
    output logic              cycle_end_o
);

    step_e step;
    logic  run, adv, wrap;

    seq_step_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .adv_i    (adv),
        .vlow_ok_i(vlow_ok_i),
        .chk_en_i (vlow_chk_en_i),
        .run_o    (run),
        .step_o   (step),
        .wrap_o   (wrap)
    );

    seq_handshake u_hs (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .step_i      (step),
        .conv_done_i (conv_done_i),
        .toggle_ack_i(toggle_ack_i),
        .conv_start_o(conv_start_o),
        .toggle_req_o(toggle_req_o),
        .adv_o       (adv)
    );

    // Channel code and cycle-end output
    always_comb begin
        chan_id_o   = chan_of(step);
        cycle_end_o = wrap;
    end

    // R5
    cycle_end_temp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end_o |-> (chan_id_o == CH_TEMP && conv_start_o));
    // R5
    cycle_end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_end_o |=> !cycle_end_o);

endmodule

// File: tb/sim_adc_round_robin_seq.sv
`timescale 1ns/1ps
module sim_adc_round_robin_seq;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, done = 1'b0;
    logic vok = 1'b0, chk_en = 1'b0, ack = 1'b0;
    logic [2:0] chan_id;
    logic conv_start, toggle_req, cycle_end;
    int n_tests = 0, n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_round_robin_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .conv_done_i(done),
        .vlow_ok_i(vok), .vlow_chk_en_i(chk_en), .toggle_ack_i(ack),
        .chan_id_o(chan_id), .conv_start_o(conv_start),
        .toggle_req_o(toggle_req), .cycle_end_o(cycle_end)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit en);
        chk_en = en;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        // R1: quiet while reset is held
        chk(!conv_start && !toggle_req && !cycle_end && chan_id == 0, "R1 in reset",
            {conv_start, toggle_req, cycle_end}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: idle until start
        chk(!conv_start && !toggle_req && !cycle_end && chan_id == 0, "R1 idle",
            {conv_start, toggle_req, cycle_end}, 0);
    endtask

    task automatic go();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    // One conversion step: expect code, answer after lat cycles
    task automatic conv(input int ch, input int lat, input bit end_exp, input bit spur,
                        input string tag);
        int w = 0;
        while (!conv_start && w < 40) begin @(negedge clk); w++; end
        chk(conv_start == 1'b1, {tag, " start seen"}, conv_start, 1);
        chk(chan_id == ch, tag, chan_id, ch);
        chk(cycle_end == end_exp, "R5 cycle end", cycle_end, end_exp);
        chk(toggle_req == 1'b0, "R4 no toggle in conversion", toggle_req, 0);
        if (spur) done = 1'b1;
        @(negedge clk); done = 1'b0;
        chk(conv_start == 1'b0, "R2 single start pulse", conv_start, 0);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk(chan_id == ch && !conv_start, "R2 waits for done", chan_id, ch);
        end
        done = 1'b1; @(negedge clk); done = 1'b0;
    endtask

    // One toggle step: expect request held, answer after lat cycles
    task automatic tog(input int next_ch, input int lat);
        int w = 0;
        while (!toggle_req && w < 40) begin @(negedge clk); w++; end
        chk(toggle_req == 1'b1, "R4 toggle request", toggle_req, 1);
        chk(chan_id == next_ch, "R4 toggle shows next code", chan_id, next_ch);
        chk(conv_start == 1'b0, "R4 no start in toggle", conv_start, 0);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk(toggle_req && !conv_start, "R4 request held", toggle_req, 1);
        end
        ack = 1'b1; @(negedge clk); ack = 1'b0;
        chk(toggle_req == 1'b0, "R4 advance on ack", toggle_req, 0);
    endtask

    // One full round, R3 order, with latencies swept by c
    task automatic full_round(input int c, input bit first_end);
        conv(0, c % 4, first_end, c[0], "R3 temp");
        conv(1, (c + 1) % 4, 1'b0, 1'b0, "R3 supply");
        conv(2, (c + 2) % 4, 1'b0, c[1], "R3 bias");
        tog(3, (c + 3) % 4);
        conv(3, (c + 1) % 4, 1'b0, 1'b1, "R3 rx coarse");
        conv(4, c % 4, 1'b0, 1'b0, "R3 rx fine");
        conv(5, (c + 2) % 4, 1'b0, 1'b0, "R3 tx power");
        tog(0, c % 4);
    endtask

    initial begin
        // Scenario A: no restricted loop; R9 vlow flag and R6 late enable ignored
        do_reset(1'b0);
        chk_en = 1'b1;  // R6: change after reset has no effect
        go();
        for (int c = 0; c < 4; c++) begin
            vok = c[0];  // R9
            full_round(c, c != 0);
        end
        conv(0, 1, 1'b1, 1'b0, "R9 temp after rounds");
        // R1: reset taken mid-sequence returns to idle
        conv(1, 2, 1'b0, 1'b0, "R3 supply before reset");
        repeat (2) @(negedge clk);
        do_reset(1'b0);
        repeat (4) @(negedge clk);
        chk(!conv_start && chan_id == 0, "R1 idle after mid reset", conv_start, 0);

        // Scenario B: restricted loop, supply stays low several times
        vok = 1'b0;
        do_reset(1'b1);
        go();
        conv(0, 0, 1'b0, 1'b0, "R8 temp first");
        for (int k = 0; k < 3; k++) begin
            conv(1, k, 1'b0, 1'b0, "R8 supply low");
            conv(0, k, 1'b1, 1'b0, "R8 back to temp");
        end
        vok = 1'b1;
        conv(1, 1, 1'b0, 1'b0, "R7 supply ok");
        conv(2, 0, 1'b0, 1'b0, "R7 bias after exit");
        vok = 1'b0;  // R7: full round kept
        tog(3, 1);
        conv(3, 0, 1'b0, 1'b0, "R7 rx coarse");
        conv(4, 0, 1'b0, 1'b0, "R7 rx fine");
        conv(5, 0, 1'b0, 1'b0, "R7 tx power");
        tog(0, 0);
        conv(0, 0, 1'b1, 1'b0, "R7 temp");
        conv(1, 0, 1'b0, 1'b0, "R7 supply low later");
        conv(2, 0, 1'b0, 1'b0, "R7 bias stays full");

        // Scenario C: restricted, supply already ok at first reading
        vok = 1'b1;
        do_reset(1'b1);
        chk_en = 1'b0;  // R6: late change ignored
        go();
        vok = 1'b0;
        conv(0, 2, 1'b0, 1'b0, "R6 temp");
        vok = 1'b1;
        conv(1, 3, 1'b0, 1'b0, "R6 supply ok");
        vok = 1'b0;
        conv(2, 1, 1'b0, 1'b0, "R6 bias next");
        tog(3, 2);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule